// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing half of a 2K x 8 serial EEPROM. It runs on a fast system clock and oversamples the two open-drain bus lines, SCL and SDA. It finds START and STOP conditions, decodes the slave address byte and acknowledges on the ninth clock. It also sends read data back on SDA. It never drives the bus high: `sda_oe` high means "pull SDA low".

The three bits between the device code and the R/W bit do not select a device. They are address bits 10..8, so each address byte reaches one of eight 256-byte blocks. A word-address byte supplies the low eight bits. Write bytes leave the engine one at a time on a write port to an external page buffer, and the buffer is told to commit on the next STOP. Reads go to an external synchronous RAM with one cycle of latency. Reads are served from an internal address counter. After a read the counter points one past the last byte read. After a write it stays on the last byte written.

Top module: `eeprom_link_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and it is recognised in every state. Even in the middle of a byte, a START restarts slave-address decoding.
- R2: Both bus inputs pass a two-stage synchronizer before edge detection. `sda_oe` high pulls SDA low. `sda_oe` changes only while SCL is low, after a falling SCL edge.
- R3: The slave address byte is sent MSB first. An address byte whose bits 7..4 are 1010 is acknowledged, with SDA held low during the ninth clock. Its bits 3..1 become memory address bits 10..8. Bit 0 = 1 requests a read and bit 0 = 0 a write.
- R4: In write mode the engine acknowledges the word-address byte and every data byte.
- R5: A slave address byte whose bits 7..4 are not 1010 gets no acknowledge. Every later bit is ignored until the next START: no acknowledge, no write-port pulse, no change to the address counter.
- R6: Each received data byte gives a one-cycle `wr_valid` pulse carrying its address and data. Successive bytes advance only address bits 3..0, wrapping inside the 16-byte page.
- R7: `wr_commit` pulses for one cycle on a STOP only if at least one data byte came in since the last START. A write that carries only a word address, as in a random read, gives no commit.
- R8: A random read returns the byte at {block bits, word address}. A random read is a write-mode address, a word address, a repeated START, then a read-mode address.
- R9: During a read, a low acknowledge from the master after a byte makes the engine send the next address. The address advances over all 11 bits and wraps from 0x7FF to 0x000.
- R10: A high (not-acknowledge) after a read byte releases SDA. The engine then stays silent until the next START.
- R11: After a read, a current read (read-mode address with no word address) returns the last address read plus one. After a write it returns the last address written. Either way the block bits come from the new address byte.
- R12: Each fetch is a one-cycle `mem_rd` pulse with `mem_addr` valid in that cycle. The data is taken from `mem_rdata` one cycle later.
- R13: Out of reset, `sda_oe`, `mem_rd`, `wr_valid` and `wr_commit` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| mem_rd | output | 1 | One-cycle read strobe to the array |
| mem_addr | output | 11 | Address counter, array read address |
| mem_rdata | input | 8 | Array read data, one cycle after `mem_rd` |
| wr_valid | output | 1 | One-cycle pulse: a write byte is ready |
| wr_addr | output | 11 | Address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle pulse: program the buffered page |

## Verification
On the SCL falling edge that closes a read byte, two things happen in the same system-clock cycle: the address counter advances, and the fetch for the next byte is issued. The array must therefore see the advanced address. The bench provokes this with sequential reads across the 0x7FF to 0x000 boundary, a 16-byte run, and current reads straight after reads. Each returned byte is judged against a behavioural memory model. A stale or doubled address shows up as a wrong byte.

// File: rtl/eeprom_link_pkg.sv
`timescale 1ns/1ps
package eeprom_link_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_WADR, PH_WDAT, PH_ACK, PH_RDAT, PH_MACK
  } phase_t;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eeprom_link_sync.sv
`timescale 1ns/1ps
module eeprom_link_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '1;
      else        sr <= {sr[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sr[STAGES-1];
  end
endmodule

// File: rtl/eeprom_link_cond.sv
`timescale 1ns/1ps
module eeprom_link_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_link_slave.sv
`timescale 1ns/1ps
module eeprom_link_slave
  import eeprom_link_pkg::*;
#(
  parameter int BLK_W       = 3,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             mem_rd,
  output logic [BLK_W+7:0] mem_addr,
  input  logic [7:0]       mem_rdata,
  output logic             wr_valid,
  output logic [BLK_W+7:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             wr_commit
);
  localparam int AW = BLK_W + 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sr;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_q_n = rst_sr[1];

  logic [1:0] line_s;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  eeprom_link_sync #(.STAGES(SYNC_STAGES), .LINES(2)) i_sync (
    .clk(clk), .rst_n(rst_q_n), .d_i({scl_i, sda_i}), .q_o(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  eeprom_link_cond i_cond (
    .clk(clk), .rst_n(rst_q_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  phase_t          ph, ph_d, ret, ret_d;
  logic [3:0]      cnt, cnt_d;
  logic [7:0]      sh, sh_d, rb, rb_d;
  logic            oe, oe_d, pend, pend_d, cont, cont_d;
  logic            rd, rd_d, ld, wv_d, cm_d;
  logic [BLK_W-1:0] blk, blk_d;
  logic [AW-1:0]   ctr, ctr_d, wp, wp_d, wa_q, wa_d;
  logic [7:0]      wd_q, wd_d;
  logic            wv_q, cm_q;

  always_comb begin
    ph_d = ph;  ret_d = ret;  cnt_d = cnt;  sh_d = sh;  rb_d = rb;
    oe_d = oe;  blk_d = blk;  ctr_d = ctr;  wp_d = wp;  pend_d = pend;
    cont_d = cont;  rd_d = 1'b0;  wv_d = 1'b0;  cm_d = 1'b0;
    wa_d = wa_q;  wd_d = wd_q;
    if (ld) rb_d = mem_rdata;
    if (start_ev) begin
      ph_d = PH_DEV;  cnt_d = '0;  oe_d = 1'b0;  pend_d = 1'b0;
    end else if (stop_ev) begin
      ph_d = PH_IDLE;  oe_d = 1'b0;  cm_d = pend;  pend_d = 1'b0;
    end else begin
      case (ph)
        PH_DEV, PH_WADR, PH_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh[6:0], sda_s};
            cnt_d = 4'(cnt + 1'b1);
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_d = '0;
            if (ph == PH_DEV) begin
              if (sh[7:4] == DEV_CODE) begin
                blk_d = sh[BLK_W:1];
                ctr_d = {sh[BLK_W:1], ctr[7:0]};
                oe_d  = 1'b1;
                ph_d  = PH_ACK;
                ret_d = sh[0] ? PH_RDAT : PH_WADR;
                rd_d  = sh[0];
              end else begin
                ph_d = PH_IDLE;
              end
            end else if (ph == PH_WADR) begin
              ctr_d = {blk, sh};
              wp_d  = {blk, sh};
              oe_d  = 1'b1;
              ph_d  = PH_ACK;
              ret_d = PH_WDAT;
            end else begin
              wv_d   = 1'b1;
              wa_d   = wp;
              wd_d   = sh;
              ctr_d  = wp;
              wp_d   = {wp[AW-1:PAGE_W], PAGE_W'(wp[PAGE_W-1:0] + 1'b1)};
              pend_d = 1'b1;
              oe_d   = 1'b1;
              ph_d   = PH_ACK;
              ret_d  = PH_WDAT;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            ph_d = ret;
            if (ret == PH_RDAT) begin
              oe_d  = ~rb[7];
              rb_d  = {rb[6:0], 1'b0};
              cnt_d = 4'd1;
            end else begin
              oe_d  = 1'b0;
              cnt_d = '0;
            end
          end
        end
        PH_RDAT: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_d  = 1'b0;
              ph_d  = PH_MACK;
              ctr_d = AW'(ctr + 1'b1);
              rd_d  = 1'b1;
            end else begin
              oe_d  = ~rb[7];
              rb_d  = {rb[6:0], 1'b0};
              cnt_d = 4'(cnt + 1'b1);
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) cont_d = ~sda_s;
          else if (scl_fall) begin
            if (cont) begin
              ph_d  = PH_RDAT;
              oe_d  = ~rb[7];
              rb_d  = {rb[6:0], 1'b0};
              cnt_d = 4'd1;
            end else begin
              ph_d = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ph <= PH_IDLE;  ret <= PH_IDLE;  cnt <= '0;  sh <= '0;  rb <= '0;
      oe <= 1'b0;  blk <= '0;  ctr <= '0;  wp <= '0;  pend <= 1'b0;
      cont <= 1'b0;  rd <= 1'b0;  ld <= 1'b0;  wv_q <= 1'b0;  cm_q <= 1'b0;
      wa_q <= '0;  wd_q <= '0;
    end else begin
      ph <= ph_d;  ret <= ret_d;  cnt <= cnt_d;  sh <= sh_d;  rb <= rb_d;
      oe <= oe_d;  blk <= blk_d;  ctr <= ctr_d;  wp <= wp_d;  pend <= pend_d;
      cont <= cont_d;  rd <= rd_d;  ld <= rd;  wv_q <= wv_d;  cm_q <= cm_d;
      if (wv_d) begin
        wa_q <= wa_d;
        wd_q <= wd_d;
      end
    end
  end

  assign sda_oe    = oe;
  assign mem_rd    = rd;
  assign mem_addr  = ctr;
  assign wr_valid  = wv_q;
  assign wr_addr   = wa_q;
  assign wr_data   = wd_q;
  assign wr_commit = cm_q;

  // R2: the pull-down only starts right after a falling SCL edge
  a_r2_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R10: a STOP always leaves the line released
  a_r10_release_on_stop: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(stop_ev) |-> !sda_oe);
  // R12: the fetch strobe is a single-cycle pulse
  a_r12_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_rd |=> !mem_rd);
  // R7: commit follows a detected STOP
  a_r7_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_commit |-> $past(stop_ev));
  // R6: write bytes are issued from a falling SCL edge, one cycle wide
  a_r6_write_pulse: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_valid |-> ($past(scl_fall) && !$past(wr_valid)));
endmodule

// File: tb/test_eeprom_link_slave.sv
`timescale 1ns/1ps
module test_eeprom_link_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_rd, wr_valid, wr_commit;
  logic [10:0] mem_addr, wr_addr;
  logic [7:0]  mem_rdata, wr_data;
  wire         sda_bus;

  always #2 clk = ~clk;   // 250 MHz
  assign sda_bus = sda_m & ~sda_oe;

  eeprom_link_slave i_eeprom_link_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  // array and page buffer models
  logic [7:0] ram [0:2047];
  logic [7:0] mm  [0:2047];
  always @(posedge clk) if (mem_rd) mem_rdata <= ram[mem_addr];

  int n_chk = 0, n_fail = 0, commits = 0, bus_bad = 0, rd_bad = 0;
  bit done = 1'b0;
  int ex_a[$], ex_d[$], pb_a[$], pb_d[$];
  int m_ctr = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // per-clock monitors
  logic oe_prev = 1'b0, scl_prev = 1'b1, rd_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != oe_prev && scl_m && scl_prev) bus_bad++;
      if (mem_rd && rd_prev) rd_bad++;
      if (wr_valid) begin
        if (ex_a.size() == 0) chk(1'b0, "R5", "unexpected write byte", int'(wr_addr), 0);
        else begin
          int ea, ed;
          ea = ex_a.pop_front();  ed = ex_d.pop_front();
          chk(int'(wr_addr) == ea, "R6", "write address", int'(wr_addr), ea);
          chk(int'(wr_data) == ed, "R6", "write data", int'(wr_data), ed);
        end
        pb_a.push_back(int'(wr_addr));  pb_d.push_back(int'(wr_data));
      end
      if (wr_commit) begin
        foreach (pb_a[i]) ram[pb_a[i]] = 8'(pb_d[i]);
        pb_a.delete();  pb_d.delete();
        commits++;
      end
    end
    oe_prev = sda_oe;  scl_prev = scl_m;  rd_prev = mem_rd;
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic m_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(Q/2); r = sda_bus; wt(Q/2); scl_m = 1'b0; wt(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nak);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, nak);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); d[i] = r; end
    m_bit(!mack, r);
  endtask

  task automatic w_txn(input int blk, input int wa, input int n, input int seed);
    logic nak;
    int p, last, c0;
    c0 = commits;  p = blk * 256 + wa;  last = p;
    m_start();
    send_byte(8'(8'hA0 | (blk << 1)), nak);
    chk(nak == 1'b0, "R3", "write address byte ack", int'(nak), 0);
    send_byte(8'(wa), nak);
    chk(nak == 1'b0, "R4", "word address ack", int'(nak), 0);
    for (int k = 0; k < n; k++) begin
      int d;
      d = (seed + 37 * k) & 255;
      ex_a.push_back(p);  ex_d.push_back(d);
      send_byte(8'(d), nak);
      chk(nak == 1'b0, "R4", "data byte ack", int'(nak), 0);
      mm[p] = 8'(d);  last = p;
      p = (p & ~15) | ((p + 1) & 15);
    end
    m_stop();  wt(4);
    chk(commits == c0 + ((n > 0) ? 1 : 0), "R7", "commit count", commits, c0 + ((n > 0) ? 1 : 0));
    m_ctr = (n > 0) ? last : blk * 256 + wa;
  endtask

  task automatic read_run(input int a0, input int n, input string tag);
    logic [7:0] d;
    int a;
    a = a0;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk(d == mm[a], tag, "read byte", int'(d), int'(mm[a]));
      a = (a + 1) & 2047;
    end
    m_stop();  wt(4);
    m_ctr = a;
  endtask

  task automatic cur_read(input int blk, input int n, input string tag);
    logic nak;
    m_start();
    send_byte(8'(8'hA1 | (blk << 1)), nak);
    chk(nak == 1'b0, "R3", "read address byte ack", int'(nak), 0);
    read_run(blk * 256 + (m_ctr & 255), n, tag);
  endtask

  task automatic rand_read(input int blk, input int wa, input int n, input string tag);
    logic nak;
    int c0;
    c0 = commits;
    m_start();
    send_byte(8'(8'hA0 | (blk << 1)), nak);
    chk(nak == 1'b0, "R3", "write address byte ack", int'(nak), 0);
    send_byte(8'(wa), nak);
    chk(nak == 1'b0, "R4", "word address ack", int'(nak), 0);
    m_start();
    send_byte(8'(8'hA1 | (blk << 1)), nak);
    chk(nak == 1'b0, "R3", "read address byte ack", int'(nak), 0);
    read_run(blk * 256 + wa, n, tag);
    chk(commits == c0, "R7", "no commit on address-only write", commits, c0);
  endtask

  initial begin
    logic r;
    logic [7:0] d;
    for (int i = 0; i < 2048; i++) begin
      ram[i] = 8'((i * 13 + 7) & 255);
      mm[i]  = ram[i];
    end
    wt(5);
    rst_n = 1'b1;
    wt(8);
    // R13: idle outputs after reset
    chk(sda_oe == 1'b0 && mem_rd == 1'b0 && wr_valid == 1'b0 && wr_commit == 1'b0,
        "R13", "reset outputs", int'({sda_oe, mem_rd, wr_valid, wr_commit}), 0);

    w_txn(1, 8'h10, 1, 8'h5A);           // byte write
    rand_read(1, 8'h10, 1, "R8");        // reads 0x110
    cur_read(1, 1, "R11");               // after read: 0x111
    w_txn(2, 8'h3E, 4, 8'h90);           // R6 page wrap: 23E,23F,230,231
    cur_read(2, 2, "R11");               // after write: 0x231
    rand_read(7, 8'hFE, 4, "R9");        // 7FE,7FF,000,001
    cur_read(0, 1, "R11");               // 0x002
    w_txn(5, 8'h80, 16, 8'h21);          // full page
    rand_read(5, 8'h80, 16, "R9");       // 16-byte sequential run

    // R5: foreign device code, then stray bytes
    begin
      int c0;
      c0 = commits;
      m_start();
      send_byte(8'hB0, r);
      chk(r == 1'b1, "R5", "foreign address not acked", int'(r), 1);
      send_byte(8'h12, r);
      chk(r == 1'b1, "R5", "stray byte not acked", int'(r), 1);
      send_byte(8'h34, r);
      chk(r == 1'b1, "R5", "stray byte not acked", int'(r), 1);
      m_stop();  wt(4);
      chk(commits == c0, "R5", "no commit after foreign address", commits, c0);
    end
    cur_read(5, 1, "R5");                // counter untouched: 0x590

    // R10: not-acknowledge then extra clocks with no STOP
    m_start();
    send_byte(8'hA3, r);
    chk(r == 1'b0, "R3", "read address byte ack", int'(r), 0);
    recv_byte(1'b0, d);
    chk(d == mm[256 + (m_ctr & 255)], "R10", "last byte before nack", int'(d), int'(mm[256 + (m_ctr & 255)]));
    m_ctr = 256 + ((m_ctr + 1) & 255);
    for (int i = 0; i < 9; i++) begin
      m_bit(1'b1, r);
      chk(r == 1'b1, "R10", "bus released after nack", int'(r), 1);
    end
    m_stop();  wt(4);

    // R1: START in the middle of an address byte
    m_start();
    m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b0, r);
    rand_read(3, 8'h44, 2, "R1");

    chk(bus_bad == 0, "R2", "SDA driven change while SCL high", bus_bad, 0);
    chk(rd_bad == 0, "R12", "fetch strobe wider than one cycle", rd_bad, 0);
    chk(ex_a.size() == 0, "R6", "write bytes missing", ex_a.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++;  n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule